// File: doc/BRIEF.md
# Boot-Block Flash Protection Tracker

This block keeps the write-protection state of a 15-block flash array whose 18-bit word address space is split into eight small parameter blocks of 4K words and seven large main blocks of 32K words. A parameter decides whether the small blocks occupy the bottom or the top of the map. A command decoder upstream passes in one protection request per cycle: lock, unlock or lock-down, together with a word address. The tracker finds the addressed block and updates that block's state.

Each block is in one of three states: unlocked, locked, or locked-down. The lock-down bit is sticky and only a hardware reset clears it. When the write-protect pin is low, a locked-down block is frozen: its protection cannot change and it cannot be written. When the pin is high, lock-down has no effect and each block can be locked or unlocked on its own. A second address port looks up one block. For that block the tracker returns a write-permission flag for the program and erase sequencer, and a 16-bit status word for signature reads. A low-voltage lockout flag refuses every write, whatever state the block is in.

Top module: `flash_lock_mgr`

## Requirements
- R1: With the bottom map (TOP_BOOT=0), words 00000h-07FFFh form parameter blocks of 4K words each, and 08000h-3FFFFh form main blocks of 32K words each. Each command and query affects only the block that holds its address.
- R2: With the top map (TOP_BOOT=1), words 38000h-3FFFFh form the 4K-word parameter blocks, and 00000h-37FFFh form the 32K-word main blocks.
- R3: While rst_n is low, every block goes to locked and its lock-down bit is cleared. It is still locked when reset is released.
- R4: With cmd_valid high, cmd_op 2'b01 locks the addressed block and cmd_op 2'b10 unlocks it, unless R6 applies. The new state is visible from the cycle after the clock edge.
- R5: cmd_op 2'b11 sets the addressed block's lock-down bit and locks it. The lock-down bit then stays set until reset, even if the block is later unlocked while wp_n is high.
- R6: While wp_n is low, a lock or unlock command to a block whose lock-down bit is set is ignored, and wr_ok is low for that block.
- R7: While wp_n is high, a block whose lock-down bit is set can be unlocked, and wr_ok then follows the lock bit alone. A block without a lock-down bit is unlocked normally whatever the level of wp_n.
- R8: lock_stat reports the block at rd_addr. Bit 0 is the lock bit, bit 1 is the lock-down bit, and bits 15:2 read as zero.
- R9: wr_ok is high only when the block at rd_addr is unlocked, is not frozen by lock-down with wp_n low, and vlo is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cmd_valid | input | 1 | A protection command is presented this cycle |
| cmd_op | input | 2 | 01 lock, 10 unlock, 11 lock-down, 00 no operation |
| cmd_addr | input | 18 | Word address that selects the target block |
| wp_n | input | 1 | Write-protect pin; low enforces lock-down |
| vlo | input | 1 | Low-voltage lockout; high refuses all writes |
| rd_addr | input | 18 | Word address of the block being queried |
| wr_ok | output | 1 | Program or erase is allowed at rd_addr |
| lock_stat | output | 16 | Status word for rd_addr: bit 0 locked, bit 1 locked-down |

## Verification
The bench builds two copies of the block side by side, one with TOP_BOOT=0 and one with TOP_BOOT=1, and drives both from the same inputs. The bottom-map copy runs the table of commands. That table reaches the first and last word of each region and walks every lock-state transition under both levels of wp_n. The top-map copy is then checked on its own after a reset, at the boundaries between 4K and 32K blocks that only the top layout has, so both branches of the address map are exercised.

// File: rtl/flm_pkg.sv
package flm_pkg;

    typedef enum logic [1:0] {
        OP_NONE     = 2'b00,
        OP_LOCK     = 2'b01,
        OP_UNLOCK   = 2'b10,
        OP_LOCKDOWN = 2'b11
    } lk_op_e;

    typedef struct packed {
        logic lk;   // block refuses writes
        logic ld;   // sticky lock-down, cleared only by reset
    } cell_t;

endpackage

// File: rtl/flm_block_map.sv
module flm_block_map #(
    parameter int ADDR_W   = 18,
    parameter int PAR_LSB  = 12,
    parameter int MAIN_LSB = 15,
    parameter int NPAR     = 8,
    parameter int NMAIN    = 7,
    parameter bit TOP_BOOT = 1'b0,
    localparam int NBLK    = NPAR + NMAIN,
    localparam int IDX_W   = $clog2(NBLK)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int SEC_W = ADDR_W - MAIN_LSB;
    localparam int SUB_W = MAIN_LSB - PAR_LSB;
    localparam logic [SEC_W-1:0] SEC_TOP = {SEC_W{1'b1}};

    logic [SEC_W-1:0] sec;
    logic [SUB_W-1:0] sub;

    assign sec = addr[ADDR_W-1:MAIN_LSB];
    assign sub = addr[MAIN_LSB-1:PAR_LSB];

    // Block numbers rise with address in both layouts.
    generate
        if (TOP_BOOT) begin : g_top
            always_comb begin
                if (sec == SEC_TOP)
                    idx = IDX_W'(NMAIN) + IDX_W'(sub);
                else
                    idx = IDX_W'(sec);
            end
        end else begin : g_bot
            always_comb begin
                if (sec == '0)
                    idx = IDX_W'(sub);
                else
                    idx = IDX_W'(NPAR - 1) + IDX_W'(sec);
            end
        end
    endgenerate

endmodule

// File: rtl/flm_lock_cell.sv
module flm_lock_cell
    import flm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   hit,
    input  lk_op_e op,
    input  logic   wp_n,
    output logic   lk,
    output logic   ld
);
    cell_t st_d, st_q;
    logic  frozen;

    assign frozen = st_q.ld && !wp_n;

    always_comb begin
        st_d = st_q;
        if (hit) begin
            unique case (op)
                OP_LOCK:     if (!frozen) st_d.lk = 1'b1;
                OP_UNLOCK:   if (!frozen) st_d.lk = 1'b0;
                OP_LOCKDOWN: begin
                    st_d.lk = 1'b1;
                    st_d.ld = 1'b1;
                end
                default:     st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lk: 1'b1, ld: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lk = st_q.lk;
    assign ld = st_q.ld;

endmodule

// File: rtl/flash_lock_mgr.sv
module flash_lock_mgr
    import flm_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int PAR_LSB  = 12,
    parameter int MAIN_LSB = 15,
    parameter int NPAR     = 8,
    parameter int NMAIN    = 7,
    parameter int STAT_W   = 16,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              wp_n,
    input  logic              vlo,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              wr_ok,
    output logic [STAT_W-1:0] lock_stat
);
    localparam int NBLK  = NPAR + NMAIN;
    localparam int IDX_W = $clog2(NBLK);

    logic [IDX_W-1:0] cmd_idx, rd_idx;
    logic [NBLK-1:0]  lk_vec, ld_vec;
    lk_op_e           op;

    assign op = lk_op_e'(cmd_op);

    flm_block_map #(
        .ADDR_W(ADDR_W), .PAR_LSB(PAR_LSB), .MAIN_LSB(MAIN_LSB),
        .NPAR(NPAR), .NMAIN(NMAIN), .TOP_BOOT(TOP_BOOT)
    ) u_cmd_map (
        .addr(cmd_addr),
        .idx (cmd_idx)
    );

    flm_block_map #(
        .ADDR_W(ADDR_W), .PAR_LSB(PAR_LSB), .MAIN_LSB(MAIN_LSB),
        .NPAR(NPAR), .NMAIN(NMAIN), .TOP_BOOT(TOP_BOOT)
    ) u_rd_map (
        .addr(rd_addr),
        .idx (rd_idx)
    );

    generate
        for (genvar b = 0; b < NBLK; b++) begin : g_blk
            flm_lock_cell u_cell (
                .clk  (clk),
                .rst_n(rst_n),
                .hit  (cmd_valid && (cmd_idx == IDX_W'(b))),
                .op   (op),
                .wp_n (wp_n),
                .lk   (lk_vec[b]),
                .ld   (ld_vec[b])
            );
        end
    endgenerate

    logic sel_lk, sel_ld;

    always_comb begin
        sel_lk    = lk_vec[rd_idx];
        sel_ld    = ld_vec[rd_idx];
        wr_ok     = !sel_lk && !(sel_ld && !wp_n) && !vlo;
        lock_stat = '0;
        lock_stat[0] = sel_lk;
        lock_stat[1] = sel_ld;
    end

endmodule

// File: rtl/flm_chk.sv
module flm_chk #(
    parameter int NBLK   = 15,
    parameter int STAT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_n,
    input logic              vlo,
    input logic              wr_ok,
    input logic [STAT_W-1:0] lock_stat,
    input logic [NBLK-1:0]   lk_vec,
    input logic [NBLK-1:0]   ld_vec
);
    AST_RESET_ALL_LOCKED: assert property (@(posedge clk)
        !rst_n |=> ((&lk_vec) && (ld_vec == '0))); // R3

    AST_LOCKOUT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        vlo |-> !wr_ok); // R9

    AST_LD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(ld_vec) & ~ld_vec) == '0)); // R5

    AST_LD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |=> ((lk_vec | ~$past(ld_vec & lk_vec)) == '1)); // R6

    AST_OK_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |-> !lock_stat[0]); // R9
endmodule

bind flash_lock_mgr flm_chk #(.NBLK(NBLK), .STAT_W(STAT_W)) u_flm_chk (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .vlo(vlo), .wr_ok(wr_ok),
    .lock_stat(lock_stat), .lk_vec(lk_vec), .ld_vec(ld_vec)
);

// File: tb/flash_lock_mgr_bench.sv
module flash_lock_mgr_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [17:0] cmd_addr = '0;
    logic        wp_n = 1'b1;
    logic        vlo = 1'b0;
    logic [17:0] rd_addr = '0;
    logic        ok_b, ok_t;
    logic [15:0] st_b, st_t;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    flash_lock_mgr #(.TOP_BOOT(1'b0)) u_flash_lock_mgr (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .wp_n(wp_n), .vlo(vlo), .rd_addr(rd_addr),
        .wr_ok(ok_b), .lock_stat(st_b)
    );

    flash_lock_mgr #(.TOP_BOOT(1'b1)) u_flash_lock_mgr_top (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .wp_n(wp_n), .vlo(vlo), .rd_addr(rd_addr),
        .wr_ok(ok_t), .lock_stat(st_t)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [17:0] addr;
        logic        wp;
        logic        lo;
        logic [17:0] q;
        logic        ok;
        logic [1:0]  st;
    } vec_t;

    localparam int NV = 18;
    // ops: 0 none, 1 lock, 2 unlock, 3 lock-down; bottom map
    localparam vec_t VEC [NV] = '{
        '{2'd0, 18'h00000, 1'b1, 1'b0, 18'h00000, 1'b0, 2'b01}, // R3
        '{2'd2, 18'h00010, 1'b1, 1'b0, 18'h00FFF, 1'b1, 2'b00}, // R4
        '{2'd0, 18'h00000, 1'b1, 1'b0, 18'h01000, 1'b0, 2'b01}, // R1
        '{2'd2, 18'h07FFF, 1'b1, 1'b0, 18'h07000, 1'b1, 2'b00}, // R1
        '{2'd0, 18'h00000, 1'b1, 1'b0, 18'h08000, 1'b0, 2'b01}, // R1
        '{2'd2, 18'h0FFFF, 1'b1, 1'b0, 18'h08000, 1'b1, 2'b00}, // R1
        '{2'd0, 18'h00000, 1'b1, 1'b0, 18'h10000, 1'b0, 2'b01}, // R1
        '{2'd0, 18'h00000, 1'b1, 1'b1, 18'h08000, 1'b0, 2'b00}, // R9
        '{2'd1, 18'h08123, 1'b1, 1'b0, 18'h08000, 1'b0, 2'b01}, // R4
        '{2'd3, 18'h3FFFF, 1'b1, 1'b0, 18'h38000, 1'b0, 2'b11}, // R5
        '{2'd2, 18'h38000, 1'b1, 1'b0, 18'h3FFFF, 1'b1, 2'b10}, // R7
        '{2'd0, 18'h00000, 1'b0, 1'b0, 18'h38000, 1'b0, 2'b10}, // R6
        '{2'd1, 18'h38000, 1'b0, 1'b0, 18'h38000, 1'b0, 2'b10}, // R6
        '{2'd3, 18'h00000, 1'b0, 1'b0, 18'h00000, 1'b0, 2'b11}, // R5
        '{2'd2, 18'h00000, 1'b0, 1'b0, 18'h00000, 1'b0, 2'b11}, // R6
        '{2'd2, 18'h07000, 1'b0, 1'b0, 18'h07000, 1'b1, 2'b00}, // R7
        '{2'd0, 18'h00000, 1'b1, 1'b0, 18'h00000, 1'b0, 2'b11}, // R8
        '{2'd2, 18'h00000, 1'b1, 1'b0, 18'h00000, 1'b1, 2'b10}  // R7
    };

    task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one command for one edge, then settle for query.
    task automatic step(input logic [1:0] op, input logic [17:0] a, input logic wp,
                        input logic lo, input logic [17:0] q);
        @(negedge clk);
        cmd_valid = (op != 2'd0);
        cmd_op    = op;
        cmd_addr  = a;
        wp_n      = wp;
        vlo       = lo;
        rd_addr   = q;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 2'd0;
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R3 reset", {ok_b, st_b}, {1'b0, 16'h0001});

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].op, VEC[i].addr, VEC[i].wp, VEC[i].lo, VEC[i].q);
            chk($sformatf("R8 vec%0d", i), {ok_b, st_b}, {VEC[i].ok, 14'h0, VEC[i].st});
        end

        // R3: reset drops lock-down bits and relocks everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(2'd0, 18'h0, 1'b0, 1'b0, 18'h00000);
        chk("R3 ld cleared", {ok_b, st_b}, {1'b0, 16'h0001});
        step(2'd0, 18'h0, 1'b0, 1'b0, 18'h38000);
        chk("R3 ld cleared top", {ok_b, st_b}, {1'b0, 16'h0001});

        // R2: top map boundaries
        step(2'd2, 18'h38000, 1'b1, 1'b0, 18'h38FFF);
        chk("R2 param0 top", {ok_t, st_t}, {1'b1, 16'h0000});
        step(2'd0, 18'h0, 1'b1, 1'b0, 18'h39000);
        chk("R2 param1 top", {ok_t, st_t}, {1'b0, 16'h0001});
        step(2'd0, 18'h0, 1'b1, 1'b0, 18'h37FFF);
        chk("R2 main6 top", {ok_t, st_t}, {1'b0, 16'h0001});
        step(2'd2, 18'h00000, 1'b1, 1'b0, 18'h07FFF);
        chk("R2 main0 top", {ok_t, st_t}, {1'b1, 16'h0000});
        step(2'd0, 18'h0, 1'b1, 1'b0, 18'h08000);
        chk("R2 main1 top", {ok_t, st_t}, {1'b0, 16'h0001});
        step(2'd0, 18'h0, 1'b1, 1'b0, 18'h3FFFF);
        chk("R2 param7 top", {ok_t, st_t}, {1'b0, 16'h0001});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule